// File: doc/BRIEF.md
# Eight-bit general-purpose I/O port with pullup control

This block is the register side of one 8-bit general-purpose I/O port on a small microcontroller bus. It holds three registers. The first is an output data latch. The second holds one direction bit per pin. The third holds one pullup enable bit per pin. The CPU reaches them through a synchronous register interface. It has an address, a write strobe, a read strobe, 8-bit write data and 8-bit read data.

Toward the pads, the block drives three values per bit: output data, output enable and pullup enable. It samples the pin level of each bit through a two-flop synchronizer. A read of the data address returns a mix, chosen bit by bit. An output pin returns its latch bit, and an input pin returns its synchronized pin level. The pullup for a pin is switched off whenever that pin is an output.

The data latch sits at offset 0x03, the direction register at 0x07 and the pullup register at 0x3D. All three reset to zero, so every pin starts as a high-impedance input with its pullup off.

Top module: `gpio8_port`

## Requirements
- R1: While reset is asserted (rst_n low), and after it, until the first write: pad_out, pad_oe and pad_pu are all 0, and reads of offsets 0x03, 0x07 and 0x3D return 0.
- R2: A write to offset 0x03 loads the data latch on the clock edge where bus_wr is high, whatever the direction bits hold. From that edge on, pad_out equals the latch.
- R3: A write to offset 0x07 loads the direction register. pad_oe equals the direction bits (1 = output). A read of 0x07 returns the stored direction bits.
- R4: A read of offset 0x03 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R5: A change on pad_in reaches the data read path after exactly two rising clock edges. After only one edge, the read still shows the old level.
- R6: Offset 0x3D is a pullup enable register that can be read and written. pad_pu for a bit is 1 only when its enable bit is 1 and its direction bit is 0. It comes back on when the bit returns to input.
- R7: Writing the latch while a bit is an input changes pad_out, but does not change what that bit returns on a read of 0x03.
- R8: A read of any address other than 0x03, 0x07 and 0x3D returns 0. A write to such an address changes no register and no pad output.
- R9: bus_rdata is 0 whenever bus_rd is low. When bus_rd is high, it follows the address combinationally in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe; the write lands on the rising edge |
| bus_rd | input | 1 | Read strobe; enables bus_rdata |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Pin input levels, asynchronous |
| pad_out | output | 8 | Output data to the pads |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pullup enable per pin |

## Verification
The assertions check several rules on every cycle. The pullup and output enable of a bit are never both active. The data latch and direction writes appear on the pads one edge later. Read data is zero outside the read strobe and at unmapped offsets. On output bits, a data read agrees with pad_out. Writes to unmapped offsets leave every pad output unchanged. Some behaviours need the bench's scenarios: the mixing of pin levels into a data read, the two-edge synchronizer latency, and the fact that a latch write to an input bit leaves its read value alone. These depend on the pin stimulus over time.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PULL = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(
        input logic [ADDR_W-1:0] addr,
        input logic [ADDR_W-1:0] data_ofs,
        input logic [ADDR_W-1:0] dir_ofs,
        input logic [ADDR_W-1:0] pull_ofs
    );
        if (addr == data_ofs)      return SEL_DATA;
        else if (addr == dir_ofs)  return SEL_DIR;
        else if (addr == pull_ofs) return SEL_PULL;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/gpio8_regs.sv
module gpio8_regs #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  gpio8_pkg::reg_sel_e sel,
    input  logic [W-1:0]        wdata,
    output logic [W-1:0]        latch_q,
    output logic [W-1:0]        dir_q,
    output logic [W-1:0]        pue_q
);
    import gpio8_pkg::*;

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic [W-1:0] pue;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA: regs_d.lat = wdata;
                SEL_DIR:  regs_d.dir = wdata;
                SEL_PULL: regs_d.pue = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign latch_q = regs_q.lat;
    assign dir_q   = regs_q.dir;
    assign pue_q   = regs_q.pue;

endmodule

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_out[b] = chain_q[LAST];
    end

endmodule

// File: rtl/gpio8_rdmux.sv
module gpio8_rdmux #(
    parameter int W = 8
) (
    input  logic                rd_en,
    input  gpio8_pkg::reg_sel_e sel,
    input  logic [W-1:0]        latch_q,
    input  logic [W-1:0]        dir_q,
    input  logic [W-1:0]        pue_q,
    input  logic [W-1:0]        pin_s,
    output logic [W-1:0]        rdata
);
    import gpio8_pkg::*;

    logic [W-1:0] mixed;

    for (genvar b = 0; b < W; b++) begin : g_mix
        assign mixed[b] = dir_q[b] ? latch_q[b] : pin_s[b];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_DATA: rdata = mixed;
                SEL_DIR:  rdata = dir_q;
                SEL_PULL: rdata = pue_q;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio8_port.sv
module gpio8_port #(
    parameter int                        W        = 8,
    parameter int                        SYNC_N   = 2,
    parameter logic [gpio8_pkg::ADDR_W-1:0] DATA_OFS = 8'h03,
    parameter logic [gpio8_pkg::ADDR_W-1:0] DIR_OFS  = 8'h07,
    parameter logic [gpio8_pkg::ADDR_W-1:0] PULL_OFS = 8'h3D
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [gpio8_pkg::ADDR_W-1:0] bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [W-1:0]                 bus_wdata,
    output logic [W-1:0]                 bus_rdata,
    input  logic [W-1:0]                 pad_in,
    output logic [W-1:0]                 pad_out,
    output logic [W-1:0]                 pad_oe,
    output logic [W-1:0]                 pad_pu
);
    import gpio8_pkg::*;

    reg_sel_e     sel;
    logic [W-1:0] latch_q, dir_q, pue_q, pin_s;

    assign sel = decode_sel(bus_addr, DATA_OFS, DIR_OFS, PULL_OFS);

    gpio8_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pue_q   (pue_q)
    );

    gpio8_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_s)
    );

    gpio8_rdmux #(.W(W)) u_rdmux (
        .rd_en   (bus_rd),
        .sel     (sel),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .pue_q   (pue_q),
        .pin_s   (pin_s),
        .rdata   (bus_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;
    assign pad_pu  = pue_q & ~dir_q;

endmodule

// File: rtl/gpio8_port_chk.sv
module gpio8_port_chk #(
    parameter int                        W        = 8,
    parameter logic [gpio8_pkg::ADDR_W-1:0] DATA_OFS = 8'h03,
    parameter logic [gpio8_pkg::ADDR_W-1:0] DIR_OFS  = 8'h07,
    parameter logic [gpio8_pkg::ADDR_W-1:0] PULL_OFS = 8'h3D
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [gpio8_pkg::ADDR_W-1:0] bus_addr,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [W-1:0]                 bus_wdata,
    input logic [W-1:0]                 bus_rdata,
    input logic [W-1:0]                 pad_in,
    input logic [W-1:0]                 pad_out,
    input logic [W-1:0]                 pad_oe,
    input logic [W-1:0]                 pad_pu
);
    logic unmapped;
    assign unmapped = (bus_addr != DATA_OFS) && (bus_addr != DIR_OFS) &&
                      (bus_addr != PULL_OFS);

    a_r1_reset_pads: assert property (@(posedge clk)
        !rst_n |-> (pad_out == '0 && pad_oe == '0 && pad_pu == '0));

    a_r2_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_OFS) |=> pad_out == $past(bus_wdata));

    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DIR_OFS) |=> pad_oe == $past(bus_wdata));

    a_r4_output_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_OFS) |->
            ((bus_rdata & pad_oe) == (pad_out & pad_oe)));

    a_r6_pull_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |-> bus_rdata == '0);

    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unmapped) |=>
            ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu)));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);

endmodule

bind gpio8_port gpio8_port_chk #(
    .W(W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS), .PULL_OFS(PULL_OFS)
) u_chk (.*);

// File: tb/gpio8_port_bench.sv
module gpio8_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DATA = 8'h03;
    localparam logic [7:0] A_DIR  = 8'h07;
    localparam logic [7:0] A_PULL = 8'h3D;

    typedef struct packed {
        logic       is_wr;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] pin;
    } op_t;

    localparam int N_OPS = 13;
    localparam op_t OPS [N_OPS] = '{
        '{1'b1, A_DIR,  8'hF0, 8'h00},
        '{1'b1, A_DATA, 8'hA5, 8'h00},
        '{1'b1, A_PULL, 8'hFF, 8'h00},
        '{1'b0, A_DATA, 8'h00, 8'h3C},
        '{1'b0, A_DIR,  8'h00, 8'h3C},
        '{1'b0, A_PULL, 8'h00, 8'h3C},
        '{1'b1, A_DIR,  8'h0F, 8'h3C},
        '{1'b0, A_DATA, 8'h00, 8'hC3},
        '{1'b1, A_DATA, 8'h5A, 8'hC3},
        '{1'b0, A_DATA, 8'h00, 8'h00},
        '{1'b0, 8'h10,  8'h00, 8'hFF},
        '{1'b1, A_DIR,  8'h00, 8'hFF},
        '{1'b0, A_DATA, 8'h00, 8'h99}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_lat = '0, m_dir = '0, m_pue = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio8_port u_gpio8_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic check_pads(input string tag);
        check(tag, "pad_out", pad_out, m_lat);
        check(tag, "pad_oe",  pad_oe,  m_dir);
        check(tag, "pad_pu",  pad_pu,  m_pue & ~m_dir);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == A_DATA) m_lat = d;
        else if (a == A_DIR) m_dir = d;
        else if (a == A_PULL) m_pue = d;
    endtask

    task automatic settle_pins(input logic [7:0] p);
        @(negedge clk);
        pad_in = p;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == A_DATA) return (m_lat & m_dir) | (pad_in & ~m_dir);
        if (a == A_DIR)  return m_dir;
        if (a == A_PULL) return m_pue;
        return 8'h00;
    endfunction

    task automatic read_check(input string tag, input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(tag, "bus_rdata", bus_rdata, model_read(a));
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs held low during reset
        check_pads("R1");
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R1", A_DATA);
        read_check("R1", A_DIR);
        read_check("R1", A_PULL);
        check_pads("R1");

        // table walk: R2 R3 R4 R6 R8
        for (int i = 0; i < N_OPS; i++) begin
            if (OPS[i].is_wr) begin
                do_write(OPS[i].addr, OPS[i].data);
                check_pads(OPS[i].addr == A_DIR ? "R3" :
                           OPS[i].addr == A_DATA ? "R2" : "R6");
            end else begin
                settle_pins(OPS[i].pin);
                read_check(OPS[i].addr == A_DATA ? "R4" :
                           OPS[i].addr == A_DIR ? "R3" :
                           OPS[i].addr == A_PULL ? "R6" : "R8", OPS[i].addr);
            end
        end

        // R5: two-edge synchronizer latency, all bits input
        settle_pins(8'h00);
        pad_in = 8'hFF;
        @(posedge clk); @(negedge clk);
        bus_addr = A_DATA; bus_rd = 1'b1; #1;
        check("R5", "after one edge", bus_rdata, 8'h00);
        bus_rd = 1'b0;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b1; #1;
        check("R5", "after two edges", bus_rdata, 8'hFF);
        bus_rd = 1'b0;

        // R7: latch write to input bits leaves read value alone
        settle_pins(8'h00);
        do_write(A_DATA, 8'hFF);
        check("R7", "pad_out", pad_out, 8'hFF);
        bus_addr = A_DATA; bus_rd = 1'b1; #1;
        check("R7", "read input bits", bus_rdata, 8'h00);
        bus_rd = 1'b0;

        // R6: pullup masked by output, restored on return to input
        do_write(A_PULL, 8'hFF);
        do_write(A_DIR, 8'hFF);
        check("R6", "pad_pu outputs", pad_pu, 8'h00);
        do_write(A_DIR, 8'h00);
        check("R6", "pad_pu inputs", pad_pu, 8'hFF);

        // R8: unmapped write changes nothing
        do_write(A_DIR, 8'h3C);
        do_write(8'h3E, 8'hFF);
        do_write(8'h00, 8'hFF);
        check_pads("R8");
        read_check("R8", A_DIR);
        read_check("R8", 8'h3E);

        // R9: no strobe, no data; with strobe, same-cycle data
        @(negedge clk);
        bus_addr = A_DIR; bus_rd = 1'b0; #1;
        check("R9", "rd low", bus_rdata, 8'h00);
        bus_rd = 1'b1; #1;
        check("R9", "rd high", bus_rdata, 8'h3C);
        bus_addr = A_PULL; #1;
        check("R9", "addr change", bus_rdata, 8'hFF);
        bus_rd = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule